// File: doc/BRIEF.md
# Two-Port Shared Memory Arbiter with Atomic Lock Hold

This block sits between two independent processors and one small RAM that both can read and write. Each side has its own address, request strobe, write enable, write data, read data, an active-low lock input and an active-low ready output. When the two sides touch different words in the same cycle, both accesses go through at once. When they touch the same word in the same cycle, one side is served and the other sees ready pulled low for that cycle. The served side is port A, unless port B already owns a lock.

A side that is served while its lock input is low becomes the lock owner for that word. From then on, any request from the other side to that word is stalled. Once the other side has been stalled under an active lock, the stall is latched. Its ready output stays low, whatever address it presents, until the owner raises its lock input.

This makes a test-and-set sequence atomic across the two processors, even though arbitration is decided cycle by cycle. The owner reads 0 and writes 1 while holding its lock. The other side is released only afterwards, and it then reads the 1 that was left behind. Read data is combinational from the addressed word. A write takes effect at the clock edge that ends the granted cycle.

Top module: `dual_port_lock_arbiter`

## Requirements
- R1: The synchronous active-low reset clears any lock owner and any latched stall, so both ready outputs read high once reset has been applied. This holds even if a lock input is still low.
- R2: Requests to two different addresses with no lock in force are both served in the same cycle with both ready outputs high. Each read returns the stored word, and each write is visible from the next cycle on.
- R3: When both sides request the same address in the same cycle and neither is blocked by a lock, port A is served and port B sees ready low in that cycle. Port B's write in that cycle is discarded.
- R4: A same-address stall with no lock involved lasts only the conflicting cycle. Ready follows the conflict in the same cycle, with no register delay.
- R5: If port B is stalled in a cycle where port A is served with its lock input low, B's ready stays low in every following cycle, at any address, until A's lock input is high. All of B's writes in that time are discarded.
- R6: In the first cycle in which the owner's lock input is high, the stalled side's ready goes high and its access is served in that same cycle.
- R7: A side that is served with its lock low holds that word until its lock rises. The other side is then stalled only on that word, and still reaches other words freely until it has been stalled once.
- R8: In a test-and-set race on a word holding 0, the winner reads 0 and writes 1. The loser, once released, reads 1.
- R9: Lock ownership is symmetric: while port B owns a word, a port A request to it is stalled with port A's ready low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| a_req | input | 1 | Port A access request |
| a_we | input | 1 | Port A write enable (1 = write) |
| a_lock_n | input | 1 | Port A lock, active low |
| a_addr | input | ADDR_W | Port A word address |
| a_wdata | input | DATA_W | Port A write data |
| a_rdata | output | DATA_W | Port A read data (word at a_addr) |
| a_ready_n | output | 1 | Port A ready, low = stalled |
| b_req | input | 1 | Port B access request |
| b_we | input | 1 | Port B write enable (1 = write) |
| b_lock_n | input | 1 | Port B lock, active low |
| b_addr | input | ADDR_W | Port B word address |
| b_wdata | input | DATA_W | Port B write data |
| b_rdata | output | DATA_W | Port B read data (word at b_addr) |
| b_ready_n | output | 1 | Port B ready, low = stalled |

## Verification
The bench builds the block with its default parameters: 4 address bits and 8 data bits. The 16-word memory is then small enough that a few named words can act as semaphores, scratch words and "other address" targets, all within one short vector table. With that width, the bench can hand lock ownership from A to B and back and check discarded writes by reading the word back later. It can also reset the block in the middle of a latched stall and confirm that no stale ownership remains.

// File: rtl/dpla_pkg.sv
// Package dpla_pkg
// Purpose : shared type for the two-port lock arbiter.
// Assumes : exactly two requesting ports, named A and B.
package dpla_pkg;
    typedef enum logic {
        SIDE_A = 1'b0,
        SIDE_B = 1'b1
    } side_e;
endpackage

// File: rtl/dpla_ram.sv
// Module dpla_ram
// Purpose : word array with two write ports and two combinational read ports.
// Assumes : the arbiter never enables both writes to the same word in one cycle.
module dpla_ram #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              wa_en,
    input  logic [ADDR_W-1:0] wa_addr,
    input  logic [DATA_W-1:0] wa_data,
    input  logic              wb_en,
    input  logic [ADDR_W-1:0] wb_addr,
    input  logic [DATA_W-1:0] wb_data,
    input  logic [ADDR_W-1:0] ra_addr,
    output logic [DATA_W-1:0] ra_data,
    input  logic [ADDR_W-1:0] rb_addr,
    output logic [DATA_W-1:0] rb_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] words [DEPTH];

    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_word
        // Store one word; port A write is taken first when both target it.
        always_ff @(posedge clk) begin
            if (wa_en && (wa_addr == ADDR_W'(gi))) begin
                words[gi] <= wa_data;
            end else if (wb_en && (wb_addr == ADDR_W'(gi))) begin
                words[gi] <= wb_data;
            end
        end
    end

    // Present the addressed words on both read ports.
    always_comb begin
        ra_data = words[ra_addr];
        rb_data = words[rb_addr];
    end
endmodule

// File: rtl/dpla_lock_track.sv
// Module dpla_lock_track
// Purpose : remembers which side owns a locked word and whether the other
//           side has been caught stalling, and derives the lock-based blocks.
// Assumes : one lock owner at a time; A wins if both capture together.
module dpla_lock_track
    import dpla_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_req,
    input  logic              a_lock_n,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic              b_req,
    input  logic              b_lock_n,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic              grant_a,
    input  logic              grant_b,
    input  logic              tie_b,
    output logic              block_a,
    output logic              block_b,
    output logic              owner_busy,
    output side_e             owner_side,
    output logic              hold_q
);
    logic              own_v;
    side_e             own_side;
    logic [ADDR_W-1:0] own_addr;

    // Owner is in force only while its lock input stays low.
    always_comb begin
        owner_busy = own_v && ((own_side == SIDE_A) ? !a_lock_n : !b_lock_n);
        owner_side = own_side;
    end

    // Block the non-owner on the owned word, or everywhere once latched.
    always_comb begin
        block_a = owner_busy && (own_side == SIDE_B)
                  && (hold_q || (a_req && (a_addr == own_addr)));
        block_b = owner_busy && (own_side == SIDE_A)
                  && (hold_q || (b_req && (b_addr == own_addr)));
    end

    // Capture, keep or drop ownership and the latched stall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            own_v    <= 1'b0;
            own_side <= SIDE_A;
            own_addr <= '0;
            hold_q   <= 1'b0;
        end else if (owner_busy) begin
            hold_q <= hold_q || block_a || block_b;
        end else if (grant_a && !a_lock_n) begin
            own_v    <= 1'b1;
            own_side <= SIDE_A;
            own_addr <= a_addr;
            hold_q   <= tie_b;
        end else if (grant_b && !b_lock_n) begin
            own_v    <= 1'b1;
            own_side <= SIDE_B;
            own_addr <= b_addr;
            hold_q   <= 1'b0;
        end else begin
            own_v  <= 1'b0;
            hold_q <= 1'b0;
        end
    end

    // R1: reset leaves no owner and no latched stall.
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (!own_v && !hold_q));

    // R5: a latched stall only exists under a recorded owner.
    a_r5_hold_has_owner: assert property (@(posedge clk) disable iff (!rst_n)
        hold_q |-> own_v);
endmodule

// File: rtl/dpla_grant.sv
// Module dpla_grant
// Purpose : per-cycle arbitration between the two sides and ready outputs.
// Assumes : lock blocks come from the tracker; A wins unblocked ties.
module dpla_grant #(
    parameter int ADDR_W = 4
) (
    input  logic              a_req,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic              b_req,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic              block_a,
    input  logic              block_b,
    output logic              grant_a,
    output logic              grant_b,
    output logic              tie_b,
    output logic              a_ready_n,
    output logic              b_ready_n
);
    // Same-word conflict with no lock involved: B loses this cycle.
    always_comb begin
        tie_b = a_req && b_req && (a_addr == b_addr) && !block_a && !block_b;
    end

    // Serve each side unless blocked or beaten in a tie.
    always_comb begin
        grant_a = a_req && !block_a;
        grant_b = b_req && !block_b && !tie_b;
    end

    // Ready is low exactly while a side is held back.
    always_comb begin
        a_ready_n = !block_a;
        b_ready_n = !(block_b || tie_b);
    end
endmodule

// File: rtl/dual_port_lock_arbiter.sv
// Module dual_port_lock_arbiter
// Purpose : two processors share one RAM; same-word conflicts stall one side
//           and locked read-modify-write sequences keep the other side stalled
//           until the owner releases its lock.
// Assumes : single clock for both sides; lock and ready are active low.
module dual_port_lock_arbiter
    import dpla_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_req,
    input  logic              a_we,
    input  logic              a_lock_n,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [DATA_W-1:0] a_wdata,
    output logic [DATA_W-1:0] a_rdata,
    output logic              a_ready_n,
    input  logic              b_req,
    input  logic              b_we,
    input  logic              b_lock_n,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [DATA_W-1:0] b_wdata,
    output logic [DATA_W-1:0] b_rdata,
    output logic              b_ready_n
);
    logic  grant_a, grant_b, tie_b;
    logic  block_a, block_b;
    logic  owner_busy, hold_q;
    side_e owner_side;

    dpla_lock_track #(.ADDR_W(ADDR_W)) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .a_req     (a_req),
        .a_lock_n  (a_lock_n),
        .a_addr    (a_addr),
        .b_req     (b_req),
        .b_lock_n  (b_lock_n),
        .b_addr    (b_addr),
        .grant_a   (grant_a),
        .grant_b   (grant_b),
        .tie_b     (tie_b),
        .block_a   (block_a),
        .block_b   (block_b),
        .owner_busy(owner_busy),
        .owner_side(owner_side),
        .hold_q    (hold_q)
    );

    dpla_grant #(.ADDR_W(ADDR_W)) u_grant (
        .a_req    (a_req),
        .a_addr   (a_addr),
        .b_req    (b_req),
        .b_addr   (b_addr),
        .block_a  (block_a),
        .block_b  (block_b),
        .grant_a  (grant_a),
        .grant_b  (grant_b),
        .tie_b    (tie_b),
        .a_ready_n(a_ready_n),
        .b_ready_n(b_ready_n)
    );

    dpla_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
        .clk    (clk),
        .wa_en  (grant_a && a_we),
        .wa_addr(a_addr),
        .wa_data(a_wdata),
        .wb_en  (grant_b && b_we),
        .wb_addr(b_addr),
        .wb_data(b_wdata),
        .ra_addr(a_addr),
        .ra_data(a_rdata),
        .rb_addr(b_addr),
        .rb_data(b_rdata)
    );

    // R3 / R5: never serve both sides on one word in the same cycle.
    a_r3_single_grant_per_word: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_a && grant_b) |-> (a_addr != b_addr));

    // R2: distinct words with no lock in force are both served.
    a_r2_parallel_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (a_req && b_req && (a_addr != b_addr) && !owner_busy)
            |-> (a_ready_n && b_ready_n));

    // R3: unblocked same-word tie goes to A.
    a_r3_tie_to_a: assert property (@(posedge clk) disable iff (!rst_n)
        (a_req && b_req && (a_addr == b_addr) && !owner_busy)
            |-> (grant_a && !grant_b && !b_ready_n));

    // R5: a latched stall under A's active lock keeps B stalled.
    a_r5_hold_keeps_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_q && owner_busy && (owner_side == SIDE_A)) |-> !b_ready_n);

    // R9: a latched stall under B's active lock keeps A stalled.
    a_r9_hold_keeps_stall_a: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_q && owner_busy && (owner_side == SIDE_B)) |-> !a_ready_n);
endmodule

// File: tb/dual_port_lock_arbiter_bench.sv
module dual_port_lock_arbiter_bench;
    localparam int AW = 4;
    localparam int DW = 8;

    typedef struct packed {
        logic          ar, aw, al;
        logic [AW-1:0] aa;
        logic [DW-1:0] ad;
        logic          br, bw, bl;
        logic [AW-1:0] ba;
        logic [DW-1:0] bd;
        logic          ea, eb;   // expected ready_n
        logic          ca, cb;   // check read data
        logic [DW-1:0] xa, xb;   // expected read data
        logic [3:0]    rq;       // requirement number for messages
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VEC [NV] = '{
        // R2: parallel writes to words 1 and 2
        '{1'b1,1'b1,1'b1,4'd1,8'h00, 1'b1,1'b1,1'b1,4'd2,8'h55, 1'b1,1'b1, 1'b0,1'b0, 8'h00,8'h00, 4'd2},
        // R2: cross reads
        '{1'b1,1'b0,1'b1,4'd2,8'h00, 1'b1,1'b0,1'b1,4'd1,8'h00, 1'b1,1'b1, 1'b1,1'b1, 8'h55,8'h00, 4'd2},
        // R3: same-word writes, A wins
        '{1'b1,1'b1,1'b1,4'd3,8'h11, 1'b1,1'b1,1'b1,4'd3,8'h22, 1'b1,1'b0, 1'b0,1'b0, 8'h00,8'h00, 4'd3},
        // R4: stall over, B sees A's value
        '{1'b0,1'b0,1'b1,4'd0,8'h00, 1'b1,1'b0,1'b1,4'd3,8'h00, 1'b1,1'b1, 1'b0,1'b1, 8'h00,8'h11, 4'd4},
        // R5/R8: locked race on word 1, A reads 0
        '{1'b1,1'b0,1'b0,4'd1,8'h00, 1'b1,1'b0,1'b0,4'd1,8'h00, 1'b1,1'b0, 1'b1,1'b0, 8'h00,8'h00, 4'd5},
        // R5: A writes 1, B held at another word
        '{1'b1,1'b1,1'b0,4'd1,8'h01, 1'b1,1'b0,1'b1,4'd2,8'h00, 1'b1,1'b0, 1'b0,1'b0, 8'h00,8'h00, 4'd5},
        // R5: B write to word 2 must be dropped
        '{1'b0,1'b0,1'b0,4'd0,8'h00, 1'b1,1'b1,1'b1,4'd2,8'h99, 1'b1,1'b0, 1'b0,1'b0, 8'h00,8'h00, 4'd5},
        // R6/R8: A releases, B served at once and reads 1
        '{1'b0,1'b0,1'b1,4'd0,8'h00, 1'b1,1'b0,1'b0,4'd1,8'h00, 1'b1,1'b1, 1'b0,1'b1, 8'h00,8'h01, 4'd6},
        // R9: B owns word 1, A stalled there
        '{1'b1,1'b0,1'b1,4'd1,8'h00, 1'b1,1'b1,1'b0,4'd1,8'h01, 1'b0,1'b1, 1'b0,1'b0, 8'h00,8'h00, 4'd9},
        // R5: B releases, A reads word 2 still 55
        '{1'b1,1'b0,1'b1,4'd2,8'h00, 1'b0,1'b0,1'b1,4'd0,8'h00, 1'b1,1'b1, 1'b1,1'b0, 8'h55,8'h00, 4'd5},
        // R8: word 1 holds 1
        '{1'b1,1'b0,1'b1,4'd1,8'h00, 1'b0,1'b0,1'b1,4'd0,8'h00, 1'b1,1'b1, 1'b1,1'b0, 8'h01,8'h00, 4'd8},
        // R7: A locks word 4 alone, writes 44
        '{1'b1,1'b1,1'b0,4'd4,8'h44, 1'b0,1'b0,1'b1,4'd0,8'h00, 1'b1,1'b1, 1'b0,1'b0, 8'h00,8'h00, 4'd7},
        // R7: B reaches word 2 freely
        '{1'b0,1'b0,1'b0,4'd0,8'h00, 1'b1,1'b0,1'b1,4'd2,8'h00, 1'b1,1'b1, 1'b0,1'b1, 8'h00,8'h55, 4'd7},
        // R7: B write to owned word 4 stalled
        '{1'b0,1'b0,1'b0,4'd0,8'h00, 1'b1,1'b1,1'b1,4'd4,8'h77, 1'b1,1'b0, 1'b0,1'b0, 8'h00,8'h00, 4'd7},
        // R5: now latched, word 2 stalled too
        '{1'b0,1'b0,1'b0,4'd0,8'h00, 1'b1,1'b0,1'b1,4'd2,8'h00, 1'b1,1'b0, 1'b0,1'b0, 8'h00,8'h00, 4'd5},
        // R7: released, word 4 kept 44
        '{1'b0,1'b0,1'b1,4'd0,8'h00, 1'b1,1'b0,1'b1,4'd4,8'h00, 1'b1,1'b1, 1'b0,1'b1, 8'h00,8'h44, 4'd7},
        // R3: read tie on word 2
        '{1'b1,1'b0,1'b1,4'd2,8'h00, 1'b1,1'b0,1'b1,4'd2,8'h00, 1'b1,1'b0, 1'b1,1'b0, 8'h55,8'h00, 4'd3}
    };

    logic          clk = 1'b0;
    logic          rst_n;
    logic          a_req, a_we, a_lock_n, b_req, b_we, b_lock_n;
    logic [AW-1:0] a_addr, b_addr;
    logic [DW-1:0] a_wdata, b_wdata, a_rdata, b_rdata;
    logic          a_ready_n, b_ready_n;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    dual_port_lock_arbiter #(.ADDR_W(AW), .DATA_W(DW)) u_dual_port_lock_arbiter (
        .clk(clk), .rst_n(rst_n),
        .a_req(a_req), .a_we(a_we), .a_lock_n(a_lock_n), .a_addr(a_addr),
        .a_wdata(a_wdata), .a_rdata(a_rdata), .a_ready_n(a_ready_n),
        .b_req(b_req), .b_we(b_we), .b_lock_n(b_lock_n), .b_addr(b_addr),
        .b_wdata(b_wdata), .b_rdata(b_rdata), .b_ready_n(b_ready_n)
    );

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        a_req = v.ar; a_we = v.aw; a_lock_n = v.al; a_addr = v.aa; a_wdata = v.ad;
        b_req = v.br; b_we = v.bw; b_lock_n = v.bl; b_addr = v.ba; b_wdata = v.bd;
    endtask

    task automatic idle();
        a_req = 0; a_we = 0; a_lock_n = 1; a_addr = '0; a_wdata = '0;
        b_req = 0; b_we = 0; b_lock_n = 1; b_addr = '0; b_wdata = '0;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #400000;
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        idle();
        rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        #1;
        check("R1 a_ready_n after reset", 8'(a_ready_n), 8'd1);
        check("R1 b_ready_n after reset", 8'(b_ready_n), 8'd1);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VEC[i]);
            #1;
            check($sformatf("R%0d vec%0d a_ready_n", VEC[i].rq, i), 8'(a_ready_n), 8'(VEC[i].ea));
            check($sformatf("R%0d vec%0d b_ready_n", VEC[i].rq, i), 8'(b_ready_n), 8'(VEC[i].eb));
            if (VEC[i].ca) check($sformatf("R%0d vec%0d a_rdata", VEC[i].rq, i), a_rdata, VEC[i].xa);
            if (VEC[i].cb) check($sformatf("R%0d vec%0d b_rdata", VEC[i].rq, i), b_rdata, VEC[i].xb);
        end

        // R1: reset in the middle of a latched stall, A's lock still low.
        @(negedge clk);
        idle();
        a_req = 1; a_lock_n = 0; a_addr = 4'd5;
        b_req = 1; b_addr = 4'd5;
        #1;
        check("R5 locked tie stalls B", 8'(b_ready_n), 8'd0);
        @(negedge clk);
        a_req = 0; b_req = 0;
        rst_n = 0;
        @(negedge clk);
        rst_n = 1;
        b_req = 1; b_addr = 4'd1;
        #1;
        check("R1 B ready after mid-lock reset", 8'(b_ready_n), 8'd1);
        check("R1 B reads word 1 after reset", b_rdata, 8'h01);
        check("R1 A ready after mid-lock reset", 8'(a_ready_n), 8'd1);

        @(negedge clk);
        idle();
        @(negedge clk);
        finish_run();
    end
endmodule